// File: doc/BRIEF.md
# Banked CPU Memory Mapper

This block turns a 16-bit CPU address into a physical location. The location is a 7-bit block number and a 14-bit offset, over 128 blocks of 16 KB each. The top two address bits pick one of four bank registers. Each bank register is loaded by an I/O write.

A bank can run in one of two modes:
- **Standard mode** names one of eight low blocks for reads and a separate low block for writes.
- **Expansion mode** names any of the 128 blocks for both reads and writes.

A further I/O register holds one force bit per bank. Setting it makes the read target equal the write target, and the bank register itself is left unchanged. Memory is fitted as a contiguous run of blocks starting at block 0. An expansion block at or above the fitted count does not exist. Such a block is replaced by a low block taken from the low bits of its number, and the number of bits used depends on the internal memory size.

The outputs are combinational from the address, the access qualifiers and the registers. A register write takes effect on the first rising clock edge that samples the I/O strobe.

Top module: `bank_mapper`

## Requirements
- R1: Address bits 15:14 select bank 0..3, and `phys_offset` always equals address bits 13:0.
- R2: An I/O write to port F0h, F1h, F2h or F3h loads bank register 0, 1, 2 or 3 on the next rising edge. A write to any other port, F4h included, leaves all four bank registers unchanged.
- R3: A bank register with bit 7 = 0 is in standard mode. Its read target is block bits 6:4 and its write target is block bits 2:0. Bit 3 has no effect on either target.
- R4: A bank register with bit 7 = 1 is in expansion mode. Bits 6:0 name a single block that is used for both reads and writes.
- R5: In expansion mode, a block number from 0 to 7 maps to that same block, whatever the fitted count.
- R6: In expansion mode, a block number of 8 or more that is not below `fitted_blocks` is replaced by its low bits. `mem_size` selects how many: 0 (128 KB) keeps bits 2:0, 1 (256 KB) keeps bits 3:0, and 2 or 3 (512 KB) keeps bits 4:0.
- R7: A write to port F4h loads the force bits on the next edge. Data bit 6 goes to bank 0, bit 4 to bank 1, bit 5 to bank 2 and bit 7 to bank 3. Bits 3:0 have no effect.
- R8: When a bank is in standard mode and its force bit is 1, reads also use bits 2:0. In expansion mode the force bit has no effect.
- R9: The write target is output when `cpu_wr` = 1 and `cpu_rd` = 0. In every other case the read target is output.
- R10: Reset clears all bank registers and force bits, so every address maps to block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read or fetch qualifier |
| cpu_wr | input | 1 | Write qualifier |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| mem_size | input | 2 | Internal memory size code |
| fitted_blocks | input | 8 | Number of fitted blocks (8..128) |
| phys_block | output | 7 | Physical block number |
| phys_offset | output | 14 | Offset inside the block |

## Verification
The assertions assume the following about the inputs:
- `mem_size` and `fitted_blocks` change only while the I/O strobe is low.
- `fitted_blocks` never goes below 8.

Under these assumptions, a standard-mode bank can only produce blocks 0..7, and a replaced expansion block always lands below 32.

The random stimulus keeps within these limits:
- The fitted count is drawn only from values of 8 or more (up to 128).
- The size code is drawn from 0..3.
- Writes go to the four bank ports, the force port and several unrelated ports.

Directed cases cover the following:
- The ignored bit 3.
- Expansion numbers below 8.
- The boundary at the fitted count.
- Each size code.
- The shuffled force-bit order.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   // internal memory size code
   typedef enum logic [1:0] {
      MSZ_128K = 2'd0,
      MSZ_256K = 2'd1,
      MSZ_512K = 2'd2,
      MSZ_RSVD = 2'd3
   } mem_size_t;

   // number of block-number bits kept when an absent block is replaced
   function automatic int unsigned alias_bits(input mem_size_t sz, input int unsigned std_w);
      case (sz)
         MSZ_128K: return std_w;
         MSZ_256K: return std_w + 1;
         default:  return std_w + 2;
      endcase
   endfunction

   // force-bit position within the control byte for each bank (order is behaviour)
   function automatic int unsigned force_bit_pos(input int unsigned bank);
      case (bank)
         0:       return 6;
         1:       return 4;
         2:       return 5;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs #(
   parameter int NUM_BANKS = 4,
   parameter int REG_W     = 8,
   parameter int PORT_W    = 8,
   parameter logic [7:0] BANK_PORT_BASE = 8'hF0,
   parameter logic [7:0] CTRL_PORT      = 8'hF4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_wr,
   input  logic [PORT_W-1:0]    io_port,
   input  logic [REG_W-1:0]     io_data,
   output logic [REG_W-1:0]     bank_q [NUM_BANKS],
   output logic [NUM_BANKS-1:0] force_q
);
   import mapper_pkg::*;

   localparam int SEL_W = $clog2(NUM_BANKS);

   if (NUM_BANKS != 4) begin : g_bad_banks
      $error("mapper_regs: the force-bit order is defined for exactly four banks");
   end
   if (PORT_W != 8 || REG_W != 8) begin : g_bad_width
      $error("mapper_regs: port and register width must be 8");
   end

   logic                 ctrl_hit;
   logic [NUM_BANKS-1:0] bank_hit;

   assign ctrl_hit = io_wr && (io_port == CTRL_PORT);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [PORT_W-1:0] MY_PORT = BANK_PORT_BASE + PORT_W'(b);
      localparam int unsigned       FPOS    = force_bit_pos(b);

      assign bank_hit[b] = io_wr && (io_port == MY_PORT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           bank_q[b] <= '0;
         else if (bank_hit[b]) bank_q[b] <= io_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        force_q[b] <= 1'b0;
         else if (ctrl_hit) force_q[b] <= io_data[FPOS];
      end

      // R2
      bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (io_wr && io_port == MY_PORT) |=> (bank_q[b] == $past(io_data)));

      // R2
      bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!(io_wr && io_port == MY_PORT)) |=> $stable(bank_q[b]));

      // R7
      force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (io_wr && io_port == CTRL_PORT) |=> (force_q[b] == $past(io_data[FPOS])));
   end

   // R2: at most one bank register can be the target of a single write
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit));

   logic unused_sel;
   assign unused_sel = ^SEL_W;
endmodule

// File: rtl/mapper_bank_decode.sv
module mapper_bank_decode #(
   parameter int BLK_W = 7,
   parameter int STD_W = 3,
   parameter int FIT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BLK_W:0]       cfg,
   input  logic                 force_rw,
   input  logic [FIT_W-1:0]     fitted,
   input  mapper_pkg::mem_size_t size,
   output logic [BLK_W-1:0]     rd_blk,
   output logic [BLK_W-1:0]     wr_blk
);
   import mapper_pkg::*;

   localparam int STD_BLOCKS = 1 << STD_W;
   localparam int RD_LSB     = BLK_W - STD_W;

   if (BLK_W < 2 * STD_W + 1) begin : g_bad_fields
      $error("mapper_bank_decode: block width too small for two standard fields");
   end
   if (FIT_W != BLK_W + 1) begin : g_bad_fit
      $error("mapper_bank_decode: fitted count needs one bit more than a block number");
   end

   logic              exp_mode;
   logic [BLK_W-1:0]  ex_num;
   logic [BLK_W-1:0]  std_rd, std_wr;
   logic [BLK_W-1:0]  alias_mask;
   logic [BLK_W-1:0]  ex_eff;
   logic              ex_absent;

   assign exp_mode = cfg[BLK_W];
   assign ex_num   = cfg[BLK_W-1:0];
   assign std_wr   = BLK_W'(cfg[STD_W-1:0]);
   assign std_rd   = force_rw ? std_wr : BLK_W'(cfg[RD_LSB +: STD_W]);

   always_comb begin
      alias_mask = '0;
      for (int i = 0; i < BLK_W; i++)
         alias_mask[i] = (i < int'(alias_bits(size, STD_W)));
   end

   assign ex_absent = (int'(ex_num) >= STD_BLOCKS) && ({1'b0, ex_num} >= fitted);
   assign ex_eff    = ex_absent ? (ex_num & alias_mask) : ex_num;

   assign rd_blk = exp_mode ? ex_eff : std_rd;
   assign wr_blk = exp_mode ? ex_eff : std_wr;

   // R3
   std_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[BLK_W] |-> (int'(rd_blk) < STD_BLOCKS && int'(wr_blk) < STD_BLOCKS));

   // R4
   exp_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[BLK_W] |-> (rd_blk == wr_blk));

   // R8
   force_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_rw && !cfg[BLK_W]) |-> (rd_blk == wr_blk));

   // R6
   alias_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[BLK_W] && {1'b0, cfg[BLK_W-1:0]} >= fitted) |-> (int'(rd_blk) < 4 * STD_BLOCKS));

   // R5
   low_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[BLK_W] && int'(cfg[BLK_W-1:0]) < STD_BLOCKS) |-> (rd_blk == cfg[BLK_W-1:0]));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
   parameter int ADDR_W    = 16,
   parameter int BANK_BITS = 2,
   parameter int BLK_W     = 7,
   parameter int STD_W     = 3,
   parameter logic [7:0] BANK_PORT_BASE = 8'hF0,
   parameter logic [7:0] CTRL_PORT      = 8'hF4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [15:0]                  cpu_addr,
   input  logic                         cpu_rd,
   input  logic                         cpu_wr,
   input  logic                         io_wr,
   input  logic [7:0]                   io_port,
   input  logic [7:0]                   io_data,
   input  logic [1:0]                   mem_size,
   input  logic [7:0]                   fitted_blocks,
   output logic [6:0]                   phys_block,
   output logic [13:0]                  phys_offset
);
   import mapper_pkg::*;

   localparam int NUM_BANKS = 1 << BANK_BITS;
   localparam int OFF_W     = ADDR_W - BANK_BITS;
   localparam int REG_W     = BLK_W + 1;
   localparam int FIT_W     = BLK_W + 1;

   if (ADDR_W != 16 || OFF_W != 14 || BLK_W != 7) begin : g_bad_geom
      $error("bank_mapper: port widths assume a 16-bit address and 128 blocks");
   end

   logic [REG_W-1:0]     bank_q [NUM_BANKS];
   logic [NUM_BANKS-1:0] force_q;
   logic [BLK_W-1:0]     rd_arr [NUM_BANKS];
   logic [BLK_W-1:0]     wr_arr [NUM_BANKS];
   logic [BANK_BITS-1:0] bank_sel;
   logic                 use_wr;

   mapper_regs #(
      .NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .PORT_W(8),
      .BANK_PORT_BASE(BANK_PORT_BASE), .CTRL_PORT(CTRL_PORT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
      .io_data(io_data), .bank_q(bank_q), .force_q(force_q)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      mapper_bank_decode #(.BLK_W(BLK_W), .STD_W(STD_W), .FIT_W(FIT_W)) u_dec (
         .clk(clk), .rst_n(rst_n), .cfg(bank_q[b]), .force_rw(force_q[b]),
         .fitted(fitted_blocks), .size(mem_size_t'(mem_size)),
         .rd_blk(rd_arr[b]), .wr_blk(wr_arr[b])
      );
   end

   assign bank_sel    = cpu_addr[ADDR_W-1 -: BANK_BITS];
   assign use_wr      = cpu_wr && !cpu_rd;
   assign phys_block  = use_wr ? wr_arr[bank_sel] : rd_arr[bank_sel];
   assign phys_offset = cpu_addr[OFF_W-1:0];

   // R9: with the registers and address steady, flipping only the access type
   // changes the block only if the selected bank is in standard mode without force
   rw_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cpu_addr) && !$past(io_wr) && bank_q[bank_sel][BLK_W] && $stable(fitted_blocks)
       && $stable(mem_size)) |-> $stable(phys_block));
endmodule

// File: tb/bank_mapper_test.sv
`timescale 1ns/1ps
module bank_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0, io_wr = 1'b0;
   logic [7:0]  io_port = '0, io_data = '0;
   logic [1:0]  mem_size = '0;
   logic [7:0]  fitted_blocks = 8'd8;
   logic [6:0]  phys_block;
   logic [13:0] phys_offset;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] sh_bank [4];
   logic [3:0] sh_force;

   always #4 clk = ~clk;

   bank_mapper uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .io_wr(io_wr), .io_port(io_port), .io_data(io_data), .mem_size(mem_size),
      .fitted_blocks(fitted_blocks), .phys_block(phys_block), .phys_offset(phys_offset)
   );

   function automatic logic [6:0] model_block(input logic [7:0] cfg, input bit frc,
                                              input bit wr_path, input int fit, input int sz);
      int ex;
      if (!cfg[7]) return (wr_path || frc) ? {4'd0, cfg[2:0]} : {4'd0, cfg[6:4]};
      ex = int'(cfg[6:0]);
      if (ex < 8 || ex < fit) return 7'(ex);
      case (sz)
         0:       return 7'(ex & 7);
         1:       return 7'(ex & 15);
         default: return 7'(ex & 31);
      endcase
   endfunction

   task automatic io_write(input logic [7:0] port, input logic [7:0] data);
      @(negedge clk);
      io_wr = 1'b1; io_port = port; io_data = data;
      @(negedge clk);
      io_wr = 1'b0;
      if (port >= 8'hF0 && port <= 8'hF3) sh_bank[port[1:0]] = data;
      if (port == 8'hF4) sh_force = {data[7], data[5], data[4], data[6]};
   endtask

   task automatic check_map(input string tag, input logic [15:0] addr, input bit rd, input bit wr);
      logic [6:0] eb;
      bit wp;
      cpu_addr = addr; cpu_rd = rd; cpu_wr = wr;
      #1;
      wp = wr && !rd;
      eb = model_block(sh_bank[addr[15:14]], sh_force[addr[15:14]], wp,
                       int'(fitted_blocks), int'(mem_size));
      n_checks++;
      if (phys_block !== eb || phys_offset !== addr[13:0]) begin
         n_fail++;
         $display("FAIL %s addr=%h rd=%0b wr=%0b block=%0d/%h exp=%0d/%h", tag, addr, rd, wr,
                  phys_block, phys_offset, eb, addr[13:0]);
      end
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int fits [6] = '{8, 16, 32, 48, 100, 128};
      logic [7:0] ports [8] = '{8'hF0, 8'hF1, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hFC, 8'h80};
      void'($urandom(32'd1985));
      for (int i = 0; i < 4; i++) sh_bank[i] = '0;
      sh_force = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state maps every bank to block 0
      check_map("R10 reset bank0", 16'h1234, 1'b1, 1'b0);
      check_map("R10 reset bank3", 16'hF00D, 1'b0, 1'b1);

      // R3: split targets; bit 3 ignored
      io_write(8'hF1, 8'h5A);   // rd 5, wr 2, bit3 set
      check_map("R3 read field", 16'h4001, 1'b1, 1'b0);
      check_map("R3 write field", 16'h7FFF, 1'b0, 1'b1);
      // R1: offset passes through; R9 idle uses read path
      check_map("R1_R9 idle read path", 16'h6ABC, 1'b0, 1'b0);
      check_map("R9 both qualifiers read path", 16'h4000, 1'b1, 1'b1);

      // R7/R8: force bit for bank 1 is data bit 4
      io_write(8'hF4, 8'h10);
      check_map("R7_R8 bank1 forced", 16'h4002, 1'b1, 1'b0);
      io_write(8'hF4, 8'h4F);   // only bank0 forced, low bits ignored
      check_map("R7 bank1 released", 16'h4003, 1'b1, 1'b0);
      // R2: F4 write left bank registers alone
      check_map("R2 ctrl keeps bank", 16'h4004, 1'b0, 1'b1);

      // R4/R5/R6 expansion cases
      fitted_blocks = 8'd16; mem_size = 2'd0;
      io_write(8'hF2, 8'h85);
      check_map("R5 low expansion", 16'h8000, 1'b1, 1'b0);
      io_write(8'hF2, 8'h8F);
      check_map("R4 fitted block", 16'h9000, 1'b0, 1'b1);
      io_write(8'hF2, 8'h90);   // 16 == fitted, absent
      check_map("R6 boundary 128k", 16'hA000, 1'b1, 1'b0);
      io_write(8'hF2, 8'hFD);   // 125
      check_map("R6 alias 128k", 16'hA001, 1'b1, 1'b0);
      mem_size = 2'd1;
      check_map("R6 alias 256k", 16'hA002, 1'b0, 1'b1);
      mem_size = 2'd2;
      check_map("R6 alias 512k", 16'hA003, 1'b1, 1'b0);
      mem_size = 2'd3;
      check_map("R6 alias code3", 16'hA004, 1'b1, 1'b0);
      // R8: force bit has no effect in expansion mode (bank2 bit is D5)
      io_write(8'hF4, 8'h20);
      check_map("R8 force in expansion", 16'hA005, 1'b1, 1'b0);
      // R2: unrelated port ignored
      io_write(8'hF5, 8'h00);
      check_map("R2 other port", 16'hA006, 1'b1, 1'b0);

      // R1..R9 constrained random
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 2) == 0)
            io_write(ports[$urandom_range(0, 7)], 8'($urandom));
         if ($urandom_range(0, 7) == 0) begin
            @(negedge clk);
            fitted_blocks = 8'(fits[$urandom_range(0, 5)]);
            mem_size = 2'($urandom_range(0, 3));
         end
         check_map("R1_R9 random", 16'($urandom), 1'($urandom), 1'($urandom));
      end

      finish_run();
   end
endmodule